// File: doc/BRIEF.md
# DMA Status and Interrupt Aggregator

This block keeps the completion status of a transmit DMA channel and a receive DMA channel, and folds both into one maskable, level-sensitive interrupt. Each channel has an 8-bit count of completed packets, a sticky packet event flag and a sticky error flag. The error is a transmit underrun or a receive overflow. The DMA engines pulse strobe inputs when a packet finishes or when an error occurs. Software reads the status words through a simple 32-bit register port. It acknowledges events by writing ones back. A packet acknowledge takes one packet off the count. It does not simply clear the flag.

The register port is plain. A write is one cycle with `wr_en_i` high, and it always completes. A read is combinational from `rd_addr_i`. There is no streaming data path and no back-pressure. Status changes caused by a strobe or a write are visible on the read port in the cycle after the clock edge that captures them. The interrupt pin follows the masked vector with one further register stage.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, both status words, the mask and the interrupt vector read zero, and `irq_o` is low.
- R2: A completion strobe adds one to that channel's count in bits 23:16 and sets its event flag in bit 0.
- R3: Writing a status word with bit 0 set subtracts one from that channel's count. The event flag clears only if the new count is zero. Writing bit 0 as zero changes neither the count nor the flag.
- R4: A completion strobe and an acknowledge in the same cycle leave the count unchanged and leave the event flag set.
- R5: The count wraps modulo 256. An increment at 255 gives 0, and an acknowledge at 0 gives 255.
- R6: The error flag is bit 1 of the transmit word and bit 2 of the receive word. Its strobe sets it. Writing 1 to the flag's bit clears it, and writing 0 leaves it unchanged. A strobe in the same cycle as a clearing write wins.
- R7: Word address 0 is transmit status, 1 is receive status, 2 is the mask (bits 7:0, read back as written), and 3 is the masked interrupt vector.
- R8: The interrupt vector is {receive status bits 3:0, transmit status bits 3:0} ANDed with the mask. Writes to address 3 are ignored.
- R9: `irq_o` is registered. In each cycle it equals the OR of the masked vector as it stood in the previous cycle.
- R10: Status bits that hold no flag or count read zero. Writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done_i | input | 1 | Transmit packet completion strobe |
| tx_underrun_i | input | 1 | Transmit underrun strobe |
| rx_done_i | input | 1 | Receive packet completion strobe |
| rx_overflow_i | input | 1 | Receive overflow strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read word address |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The bench aims at five corner cases:
- An acknowledge that lands in the same cycle as a completion. A design that decrements anyway, or lets the acknowledge clear the flag, loses a packet.
- Acknowledges with several packets pending. A design that clears the flag on the first write hides pending packets.
- The wrap at 0 and at 255. A saturating design shows 255 or 0 where modulo arithmetic shows 0 or 255.
- A clearing write that collides with a fresh error strobe. A design that lets the write win drops the error.
- The one-cycle lag of `irq_o` behind the mask and the status. A combinational or two-stage pin is off by a cycle.

A long pseudo-random mix of strobes and writes to every address is compared against a model on every cycle. A full sweep of the 256 mask values checks the vector and the pin.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 8;
  localparam int CNT_LSB  = 16;
  localparam int ADDR_W   = 2;
  localparam int NIB_W    = 4;
  localparam int VEC_W    = 2 * NIB_W;
  localparam int NUM_CH   = 2;
  localparam int TX_ERR_POS = 1;
  localparam int RX_ERR_POS = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_TX   = 2'd0,
    SEL_RX   = 2'd1,
    SEL_MASK = 2'd2,
    SEL_VEC  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_stat_chan.sv
module dma_stat_chan #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int CNT_LSB = 16,
  parameter int ERR_POS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              err_i,
  input  logic              ack_we_i,
  input  logic [DATA_W-1:0] ack_data_i,
  output logic [DATA_W-1:0] stat_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             evt_q, evt_d;
  logic             err_q, err_d;
  logic             inc, dec, clr;

  assign inc = done_i;
  assign dec = ack_we_i & ack_data_i[0];
  assign clr = ack_we_i & ack_data_i[ERR_POS];

  always_comb begin
    cnt_d = cnt_q;
    evt_d = evt_q;
    if (inc && !dec) begin
      cnt_d = cnt_q + 1'b1;
      evt_d = 1'b1;
    end else if (dec && !inc) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_d == '0) evt_d = 1'b0;
    end else if (inc && dec) begin
      evt_d = 1'b1;
    end
    err_d = err_i | (err_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      evt_q <= evt_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    stat_o                   = '0;
    stat_o[CNT_LSB +: CNT_W] = cnt_q;
    stat_o[0]                = evt_q;
    stat_o[ERR_POS]          = err_q;
  end

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) && evt_q);

  // R3
  last_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt_q == CNT_W'(1)) |=> !evt_q && cnt_q == '0);

  // R3
  ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt_q != CNT_W'(1) && evt_q) |=> evt_q);

  // R4
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt_q) && evt_q);

  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> err_q);

  // R6
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !err_i) |=> !err_q);
endmodule

// File: rtl/dma_irq_comb.sv
module dma_irq_comb #(
  parameter int NIB_W  = 4,
  parameter int DATA_W = 32,
  localparam int VEC_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  tx_nib_i,
  input  logic [NIB_W-1:0]  rx_nib_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] mask_data_i,
  output logic [VEC_W-1:0]  mask_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              irq_o
);
  logic [VEC_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_data_i[VEC_W-1:0];
      irq_o <= |vec_o;
    end
  end

  assign mask_o = mask_q;
  assign vec_o  = {rx_nib_i, tx_nib_i} & mask_q;

  // R9
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|vec_o));

  // R8
  vec_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o & ~mask_q) == '0);
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_done_i,
  input  logic              tx_underrun_i,
  input  logic              rx_done_i,
  input  logic              rx_overflow_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0]  done_v, err_v, we_v;
  logic [DATA_W-1:0]  stat [NUM_CH];
  logic [VEC_W-1:0]   mask_w, vec_w;
  logic               mask_we;

  assign done_v = {rx_done_i, tx_done_i};
  assign err_v  = {rx_overflow_i, tx_underrun_i};
  assign we_v[0] = wr_en_i && (wr_addr_i == SEL_TX);
  assign we_v[1] = wr_en_i && (wr_addr_i == SEL_RX);
  assign mask_we = wr_en_i && (wr_addr_i == SEL_MASK);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    dma_stat_chan #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .CNT_LSB(CNT_LSB),
      .ERR_POS((g == 0) ? TX_ERR_POS : RX_ERR_POS)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (done_v[g]),
      .err_i     (err_v[g]),
      .ack_we_i  (we_v[g]),
      .ack_data_i(wr_data_i),
      .stat_o    (stat[g])
    );
  end

  dma_irq_comb #(
    .NIB_W (NIB_W),
    .DATA_W(DATA_W)
  ) u_comb (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_nib_i   (stat[0][NIB_W-1:0]),
    .rx_nib_i   (stat[1][NIB_W-1:0]),
    .mask_we_i  (mask_we),
    .mask_data_i(wr_data_i),
    .mask_o     (mask_w),
    .vec_o      (vec_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      SEL_TX:   rd_data_o = stat[0];
      SEL_RX:   rd_data_o = stat[1];
      SEL_MASK: rd_data_o[VEC_W-1:0] = mask_w;
      default:  rd_data_o[VEC_W-1:0] = vec_w;
    endcase
  end

  // R10
  tx_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] & ~32'h00FF_0003) == '0);

  // R10
  rx_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] & ~32'h00FF_0005) == '0);
endmodule

// File: tb/dma_irq_agg_test.sv
`timescale 1ns/100ps
module dma_irq_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_done_i = 0, tx_underrun_i = 0, rx_done_i = 0, rx_overflow_i = 0;
  logic        wr_en_i = 0;
  logic [1:0]  wr_addr_i = 0, rd_addr_i = 0;
  logic [31:0] wr_data_i = 0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  int cnt [2];
  bit evt [2];
  bit err [2];
  int msk;
  bit irq_exp;
  string phase;

  always #2 clk = ~clk;

  dma_irq_agg uut (
    .clk(clk), .rst_n(rst_n),
    .tx_done_i(tx_done_i), .tx_underrun_i(tx_underrun_i),
    .rx_done_i(rx_done_i), .rx_overflow_i(rx_overflow_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] stat_word(input int ch);
    return (32'(cnt[ch]) << 16) | (32'(err[ch]) << (ch == 0 ? 1 : 2)) | 32'(evt[ch]);
  endfunction

  function automatic logic [31:0] vec_word();
    logic [31:0] tx = stat_word(0);
    logic [31:0] rx = stat_word(1);
    return ((rx[3:0] * 32'd16) + tx[3:0]) & 32'(msk);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %h expected %h", tag, phase, act, exp);
    end
  endtask

  task automatic check_all();
    rd_addr_i = 2'd0; #0.2; chk("R2/R3/R6 tx status", rd_data_o, stat_word(0));
    rd_addr_i = 2'd1; #0.2; chk("R2/R3/R6 rx status", rd_data_o, stat_word(1));
    rd_addr_i = 2'd2; #0.2; chk("R7 mask", rd_data_o, 32'(msk));
    rd_addr_i = 2'd3; #0.2; chk("R8 vector", rd_data_o, vec_word());
    chk("R9 irq pin", 32'(irq_o), 32'(irq_exp));
  endtask

  function automatic void model_ch(input int ch, input bit inc, input bit dec,
                                   input bit eset, input bit eclr);
    int nc = (cnt[ch] + int'(inc) - int'(dec) + 256) % 256;
    if (inc) evt[ch] = 1;
    else if (dec && nc == 0) evt[ch] = 0;
    cnt[ch] = nc;
    err[ch] = eset ? 1'b1 : (eclr ? 1'b0 : err[ch]);
  endfunction

  task automatic step(input bit td, input bit tu, input bit rd, input bit ro,
                      input bit we, input logic [1:0] a, input logic [31:0] d);
    logic [31:0] prev_vec;
    @(negedge clk);
    tx_done_i = td; tx_underrun_i = tu; rx_done_i = rd; rx_overflow_i = ro;
    wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    prev_vec = vec_word();
    @(posedge clk);
    model_ch(0, td, we && a == 2'd0 && d[0], tu, we && a == 2'd0 && d[1]);
    model_ch(1, rd, we && a == 2'd1 && d[0], ro, we && a == 2'd1 && d[2]);
    if (we && a == 2'd2) msk = int'(d[7:0]);
    irq_exp = |prev_vec;
    #1;
    tx_done_i = 0; tx_underrun_i = 0; rx_done_i = 0; rx_overflow_i = 0; wr_en_i = 0;
    check_all();
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done_flag = 1;
  end

  initial begin : main
    logic [31:0] lf;
    for (int i = 0; i < 2; i++) begin cnt[i] = 0; evt[i] = 0; err[i] = 0; end
    msk = 0; irq_exp = 0;
    phase = "R1 reset";
    repeat (3) @(posedge clk);
    #1 check_all();
    @(negedge clk) rst_n = 1'b1;
    #0.5 check_all();

    phase = "R2 R3 count and ack";
    step(0,0,0,0, 1, 2'd2, 32'hFFFF_FFFF);
    for (int i = 0; i < 3; i++) step(1,0,1,0, 0, 2'd0, 0);
    for (int i = 0; i < 3; i++) step(0,0,0,0, 1, 2'd0, 32'h1);
    for (int i = 0; i < 3; i++) step(0,0,0,0, 1, 2'd1, 32'h1);
    step(0,0,0,0, 1, 2'd0, 32'h0);

    phase = "R4 same-cycle";
    step(1,0,1,0, 0, 2'd0, 0);
    step(1,0,0,0, 1, 2'd0, 32'h1);
    step(0,0,1,0, 1, 2'd1, 32'h1);

    phase = "R5 wrap";
    step(0,0,0,0, 1, 2'd0, 32'h1);
    step(0,0,0,0, 1, 2'd0, 32'h1);
    step(0,0,0,0, 1, 2'd1, 32'h1);
    for (int i = 0; i < 260; i++) step(1,0,1,0, 0, 2'd0, 0);

    phase = "R6 error flags";
    step(0,1,0,1, 0, 2'd0, 0);
    step(0,0,0,0, 1, 2'd0, 32'h4);
    step(0,0,0,0, 1, 2'd1, 32'h2);
    step(0,1,0,0, 1, 2'd0, 32'h2);
    step(0,0,0,1, 1, 2'd1, 32'h4);
    step(0,0,0,0, 1, 2'd0, 32'h2);
    step(0,0,0,0, 1, 2'd1, 32'h4);

    phase = "R8 vector write ignored";
    step(1,1,1,1, 1, 2'd3, 32'hFFFF_FFFF);
    step(0,0,0,0, 1, 2'd3, 32'h0);

    phase = "R8 R9 mask sweep";
    for (int m = 0; m < 256; m++) begin
      step(0,0,0,0, 1, 2'd2, 32'(m) | 32'hA500_0000);
      step(0,0,0,0, 0, 2'd0, 0);
    end

    phase = "R10 random mix";
    lf = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      step(lf[0] & lf[1], lf[2] & lf[3] & lf[4], lf[5] & lf[6], lf[7] & lf[8] & lf[9],
           lf[10], lf[12:11], {lf[31:13], lf[12:0]} ^ {8'h0, lf[23:0]});
    end
    done_flag = 1;
  end

  initial begin
    wait (done_flag);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule